// File: doc/BRIEF.md
# Indirect Guest Bus Bridge

This block lets a 32-bit host register port reach two byte-wide peripheral devices on a slow, multiplexed local bus. The host sees a single 32-bit command register. Each write to that register starts one local-bus cycle. The cycle is aimed at one of the two devices. It either loads a register offset into the device's address latch or moves one byte through the device's data port, in the direction the command selects.

A full peripheral register access therefore takes two commands. The first writes the offset into the address latch. The second reads or writes the data port. A FIFO-style port can be read or written repeatedly, provided the offset is loaded again before each byte. The host polls a pending bit in the same register until it clears. It then issues the next command or takes the byte a read cycle returned, which appears in the low byte of the register.

On the guest side, each cycle follows a fixed order. The chip select goes active first, then the address-latch or data-select line, then the read or write strobe. The strobe is held for a parameterised number of clocks, after which everything is released in the same clock.

Top module: `indirect_guest_bridge`

## Requirements
- R1: After reset the pending bit reads 0, both chip selects are high, both strobes are high, both select lines and the data-drive enable are low, and a read of the command register returns 0x00000000.
- R2: The command register sits at byte offset 0x200 (parameter). A write to any other offset starts no guest cycle, and a read of any other offset returns 0.
- R3: Bit 25 of the command register reads 1 from the clock after an accepted command until the guest cycle ends, which is 2 + STROBE_CYCLES clocks later.
- R4: Bit 23 gives the direction (1 = write to guest, 0 = read from guest). On a write cycle the strobe is `guest_wr_n`, and `guest_dout` carries bits 7:0 with `guest_doe` high. On a read cycle the strobe is `guest_rd_n` and `guest_doe` stays low.
- R5: Bit 20 selects the device: 0 drives `guest_cs_n` to 2'b10 and 1 drives it to 2'b01. At most one chip select is ever low.
- R6: Bit 16 selects the guest register: 0 raises `guest_ale` (address latch) and 1 raises `guest_dsel` (data port).
- R7: A cycle runs in this order: the chip select alone for one clock, then chip select plus select line for one clock, then the strobe for exactly STROBE_CYCLES clocks (default 4). After that, chip select, select line, strobe and drive enable all release in the same clock.
- R8: On a read cycle, the byte on `guest_din` during the last strobe clock is captured and returned in bits 7:0 of the command register. A write cycle leaves the captured byte unchanged.
- R9: A command write that arrives while pending is set is dropped. The guest cycle in progress and the stored command fields are unchanged, and bit 31 (overrun) becomes 1 and stays 1.
- R10: A host write with bit 31 set clears the overrun flag and starts no guest cycle.
- R11: A host read of the command register never starts a guest cycle.
- R12: A read of the command register returns overrun in bit 31, pending in bit 25, and the direction, device and register-select bits of the last accepted command in bits 23, 20 and 16. It also returns the captured byte in bits 7:0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Byte offset of the host access |
| host_wr | input | 1 | Host write strobe, one clock per write |
| host_rd | input | 1 | Host read strobe, one clock per read |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the clock after `host_rd` |
| guest_cs_n | output | 2 | Active-low chip selects, bit i for device i |
| guest_ale | output | 1 | Address-latch select, active high |
| guest_dsel | output | 1 | Data-port select, active high |
| guest_rd_n | output | 1 | Active-low read strobe |
| guest_wr_n | output | 1 | Active-low write strobe |
| guest_dout | output | 8 | Byte driven onto the multiplexed guest bus |
| guest_doe | output | 1 | Drive enable for `guest_dout` |
| guest_din | input | 8 | Byte returned by the guest device |

## Verification
The assertions check on every clock the properties that hold no matter which command is running. They confirm that no more than one chip select is active. They confirm the ordering chip select → select line → strobe and that every strobe lasts exactly STROBE_CYCLES clocks. They also check that pending never drops before the strobe has run, that the command fields stay frozen while busy, that a write arriving while busy raises overrun, and that an idle bridge receiving no write keeps every chip select high.

Some behaviours only the directed scenarios can show, because they depend on the values the host and the guest exchange. These are the exact bit positions of the command word, the byte on the bus for a write, the byte captured and returned for a read, the timing of the pending bit as the host sees it, and the fact that off-offset accesses, flag-clear writes and reads leave the guest bus idle.

// File: rtl/igb_pkg.sv
// Shared definitions for the indirect guest bridge.
// Assumes a fixed command-word layout; the bit positions are decoded by both
// the host-side register and the bench, so they live here once.
package igb_pkg;

    localparam int NUM_DEV  = 2;
    localparam int BIT_OVR  = 31;
    localparam int BIT_PEND = 25;
    localparam int BIT_DIR  = 23;
    localparam int BIT_DEV  = 20;
    localparam int BIT_SEL  = 16;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHIP   = 2'd1,
        PH_SELECT = 2'd2,
        PH_STROBE = 2'd3
    } phase_e;

    typedef struct packed {
        logic       dir;    // 1 = write to guest
        logic       dev;    // device index
        logic       sel;    // 1 = data port, 0 = address latch
        logic [7:0] wbyte;  // byte to drive
    } cmd_t;

endpackage

// File: rtl/igb_read_capture.sv
// Holds the byte last returned by a guest read cycle.
// Assumes take is a single-clock pulse in the final strobe clock of a read.
module igb_read_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic [7:0] din,
    output logic [7:0] q
);

    // Latch the guest byte at the end of a read strobe; reset zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (take) begin
            q <= din;
        end
    end

endmodule

// File: rtl/igb_guest_seq.sv
// Guest-side cycle sequencer: chip select, then select line, then strobe held
// for STROBE_CYCLES clocks, then release. Outputs are decoded from the phase
// register and the command held by the host-side register, which is assumed
// stable while busy.
module igb_guest_seq
    import igb_pkg::*;
#(
    parameter int STROBE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  cmd_t               cmd,
    output logic               busy,
    output logic               done,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               ale,
    output logic               dsel,
    output logic               rd_n,
    output logic               wr_n,
    output logic               doe,
    output logic [7:0]         dout
);

    localparam int CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYCLES - 1);
    localparam int WID_W = $clog2(STROBE_CYCLES + 2);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sel_on;
    logic             stb;

    // Advance through the cycle phases and count strobe clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) phase_q <= PH_CHIP;
                end
                PH_CHIP: begin
                    phase_q <= PH_SELECT;
                end
                PH_SELECT: begin
                    phase_q <= PH_STROBE;
                    cnt_q   <= '0;
                end
                PH_STROBE: begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (phase_q != PH_IDLE);
    assign done   = (phase_q == PH_STROBE) && (cnt_q == LAST);
    assign sel_on = (phase_q == PH_SELECT) || (phase_q == PH_STROBE);
    assign stb    = (phase_q == PH_STROBE);

    // One chip select per device, active while a cycle targets it.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
        assign cs_n[g] = !(busy && (cmd.dev == 1'(g)));
    end

    assign ale  = sel_on && !cmd.sel;
    assign dsel = sel_on &&  cmd.sel;
    assign rd_n = !(stb && !cmd.dir);
    assign wr_n = !(stb &&  cmd.dir);
    assign doe  = busy && cmd.dir;
    assign dout = cmd.wbyte;

    // ---------------- assertions ----------------
    logic             strobe_seen;
    logic [WID_W-1:0] wid_q;

    assign strobe_seen = !rd_n || !wr_n;

    // Count consecutive strobe clocks for the width check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wid_q <= '0;
        end else if (strobe_seen) begin
            wid_q <= wid_q + 1'b1;
        end else begin
            wid_q <= '0;
        end
    end

    assert_one_chip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_seen) |-> (wid_q == WID_W'(STROBE_CYCLES)));

    assert_select_before_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_seen) |-> $past(ale || dsel));

    assert_chip_before_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale || dsel) |-> $past(!(&cs_n)));

    assert_pending_ends_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(strobe_seen));

endmodule

// File: rtl/igb_cmd_port.sv
// Host-side command register: offset decode, command acceptance, overrun flag
// and readback word. Assumes busy comes from the sequencer and that the
// sequencer reads the held command for the whole cycle.
module igb_cmd_port
    import igb_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [31:0]       host_wdata,
    input  logic              busy,
    input  logic [7:0]        cap_byte,
    output logic              start,
    output cmd_t              cmd,
    output logic [31:0]       host_rdata
);

    logic  hit;
    logic  wr_cmd;
    logic  wr_clr;
    logic  ovr_q;
    logic  [31:0] word;
    logic  unused_wbits;

    assign hit    = (host_addr == CMD_OFFSET);
    assign wr_cmd = host_wr && hit && !host_wdata[BIT_OVR];
    assign wr_clr = host_wr && hit &&  host_wdata[BIT_OVR];
    assign start  = wr_cmd && !busy;
    assign unused_wbits = ^{host_wdata[30:24], host_wdata[22:21],
                            host_wdata[19:17], host_wdata[15:8]};

    // Hold the fields of the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else if (start) begin
            cmd.dir   <= host_wdata[BIT_DIR];
            cmd.dev   <= host_wdata[BIT_DEV];
            cmd.sel   <= host_wdata[BIT_SEL];
            cmd.wbyte <= host_wdata[7:0];
        end
    end

    // Sticky overrun: set by a dropped command, cleared by a bit-31 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (wr_clr) begin
            ovr_q <= 1'b0;
        end else if (wr_cmd && busy) begin
            ovr_q <= 1'b1;
        end
    end

    // Assemble the readback word from flag, state, fields and captured byte.
    always_comb begin
        word           = '0;
        word[BIT_OVR]  = ovr_q;
        word[BIT_PEND] = busy;
        word[BIT_DIR]  = cmd.dir;
        word[BIT_DEV]  = cmd.dev;
        word[BIT_SEL]  = cmd.sel;
        word[7:0]      = cap_byte;
    end

    // Register read data one clock after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= hit ? word : '0;
        end
    end

    assert_drop_sets_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit && !host_wdata[BIT_OVR] && busy) |=> (ovr_q && $stable(cmd)));

    assert_fields_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd));

endmodule

// File: rtl/indirect_guest_bridge.sv
// Top of the indirect guest bridge: a 32-bit command register on the host
// side drives single byte cycles to one of two devices on a multiplexed
// guest bus. Assumes the host polls pending before each new command.
module indirect_guest_bridge
    import igb_pkg::*;
#(
    parameter int                ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] CMD_OFFSET    = 12'h200,
    parameter int                STROBE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic [NUM_DEV-1:0] guest_cs_n,
    output logic               guest_ale,
    output logic               guest_dsel,
    output logic               guest_rd_n,
    output logic               guest_wr_n,
    output logic [7:0]         guest_dout,
    output logic               guest_doe,
    input  logic [7:0]         guest_din
);

    logic       start;
    logic       busy;
    logic       done;
    cmd_t       cmd;
    logic [7:0] cap_byte;

    igb_cmd_port #(
        .ADDR_W     (ADDR_W),
        .CMD_OFFSET (CMD_OFFSET)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .busy       (busy),
        .cap_byte   (cap_byte),
        .start      (start),
        .cmd        (cmd),
        .host_rdata (host_rdata)
    );

    igb_guest_seq #(
        .STROBE_CYCLES (STROBE_CYCLES)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .cmd   (cmd),
        .busy  (busy),
        .done  (done),
        .cs_n  (guest_cs_n),
        .ale   (guest_ale),
        .dsel  (guest_dsel),
        .rd_n  (guest_rd_n),
        .wr_n  (guest_wr_n),
        .doe   (guest_doe),
        .dout  (guest_dout)
    );

    igb_read_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (done && !cmd.dir),
        .din   (guest_din),
        .q     (cap_byte)
    );

    assert_idle_without_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !host_wr) |=> (&guest_cs_n));

    assert_cycle_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !(&guest_cs_n)));

endmodule

// File: tb/indirect_guest_bridge_tb.sv
// Directed bench for the indirect guest bridge; each scenario task checks itself.
module indirect_guest_bridge_tb;

    localparam int          STB  = 4;
    localparam logic [11:0] CMDA = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  guest_cs_n;
    logic        guest_ale, guest_dsel, guest_rd_n, guest_wr_n, guest_doe;
    logic [7:0]  guest_dout;
    logic [7:0]  guest_din = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    indirect_guest_bridge #(.ADDR_W(12), .CMD_OFFSET(12'h200), .STROBE_CYCLES(STB)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .guest_cs_n(guest_cs_n), .guest_ale(guest_ale), .guest_dsel(guest_dsel),
        .guest_rd_n(guest_rd_n), .guest_wr_n(guest_wr_n), .guest_dout(guest_dout),
        .guest_doe(guest_doe), .guest_din(guest_din)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic dir, input logic dev,
                                             input logic sel, input logic [7:0] b);
        return {8'h00, dir, 2'b00, dev, 3'b000, sel, 8'h00, b};
    endfunction

    task automatic host_write(input logic [11:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic guest_idle_for(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, {30'b0, guest_cs_n}, 32'h3);
        end
    endtask

    // One full guest cycle with every phase checked (R4, R5, R6, R7).
    task automatic guest_cycle(input logic dir, input logic dev, input logic sel,
                               input logic [7:0] b);
        logic [1:0] exp_cs;
        exp_cs = dev ? 2'b01 : 2'b10;
        host_write(CMDA, cmd_word(dir, dev, sel, b));
        chk("R5 chip select", {30'b0, guest_cs_n}, {30'b0, exp_cs});
        chk("R7 chip phase", {28'b0, guest_ale, guest_dsel, guest_rd_n, guest_wr_n}, 32'h3);
        @(negedge clk);
        chk("R6 select line", {30'b0, guest_ale, guest_dsel}, sel ? 32'h1 : 32'h2);
        chk("R7 select phase strobes", {30'b0, guest_rd_n, guest_wr_n}, 32'h3);
        for (int i = 0; i < STB; i++) begin
            @(negedge clk);
            chk("R7 strobe held", {30'b0, guest_rd_n, guest_wr_n}, dir ? 32'h2 : 32'h1);
            chk("R4 drive enable", {31'b0, guest_doe}, {31'b0, dir});
            if (dir) chk("R4 write byte", {24'b0, guest_dout}, {24'b0, b});
        end
        @(negedge clk);
        chk("R7 release", {26'b0, guest_cs_n, guest_ale, guest_dsel, guest_rd_n, guest_wr_n},
            {26'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1});
        chk("R7 drive released", {31'b0, guest_doe}, 32'h0);
    endtask

    task automatic test_reset();
        logic [31:0] r;
        chk("R1 chip selects", {30'b0, guest_cs_n}, 32'h3);
        chk("R1 lines", {27'b0, guest_ale, guest_dsel, guest_rd_n, guest_wr_n, guest_doe}, 32'h6);
        host_read(CMDA, r);
        chk("R1 readback", r, 32'h0);
    endtask

    task automatic test_addr_write_and_pending();
        logic [31:0] r;
        host_write(CMDA, cmd_word(1'b1, 1'b0, 1'b0, 8'h1E));
        host_read(CMDA, r);
        chk("R3 pending set", {31'b0, r[25]}, 32'h1);
        repeat (STB + 3) @(negedge clk);
        host_read(CMDA, r);
        chk("R3 pending clear", {31'b0, r[25]}, 32'h0);
        chk("R12 fields after address write", r, 32'h0080_0000);
    endtask

    task automatic test_cycles_and_capture();
        logic [31:0] r;
        guest_cycle(1'b1, 1'b1, 1'b0, 8'h5F);
        guest_din = 8'hA5;
        guest_cycle(1'b0, 1'b1, 1'b1, 8'h00);
        host_read(CMDA, r);
        chk("R8 captured byte", {24'b0, r[7:0]}, 32'hA5);
        chk("R12 read command fields", r, 32'h0011_00A5);
        guest_din = 8'h3C;
        guest_cycle(1'b1, 1'b0, 1'b1, 8'h77);
        host_read(CMDA, r);
        chk("R8 write leaves capture", r, 32'h0081_00A5);
        guest_din = 8'hC3;
        guest_cycle(1'b0, 1'b0, 1'b0, 8'h00);
        host_read(CMDA, r);
        chk("R8 second capture", r, 32'h0000_00C3);
    endtask

    task automatic test_overrun();
        logic [31:0] r;
        host_write(CMDA, cmd_word(1'b1, 1'b0, 1'b0, 8'h11));
        host_write(CMDA, cmd_word(1'b1, 1'b1, 1'b1, 8'h22));
        chk("R9 cycle kept on device 0", {30'b0, guest_cs_n}, 32'h2);
        chk("R9 original select kept", {30'b0, guest_ale, guest_dsel}, 32'h2);
        repeat (STB + 2) @(negedge clk);
        host_read(CMDA, r);
        chk("R9 overrun and old fields", r, 32'h8080_00C3);
        host_write(CMDA, 32'h8000_0000);
        guest_idle_for("R10 clear starts nothing", 3);
        host_read(CMDA, r);
        chk("R10 overrun cleared", r, 32'h0080_00C3);
    endtask

    task automatic test_other_offset_and_reads();
        logic [31:0] r;
        host_write(12'h204, cmd_word(1'b1, 1'b1, 1'b1, 8'h99));
        guest_idle_for("R2 off-offset write", 4);
        host_read(12'h204, r);
        chk("R2 off-offset read", r, 32'h0);
        host_read(CMDA, r);
        guest_idle_for("R11 read starts nothing", 3);
        chk("R2 fields unchanged", r, 32'h0080_00C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_addr_write_and_pending();
        test_cycles_and_capture();
        test_overrun();
        test_other_offset_and_reads();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule